// File: doc/BRIEF.md
# NAND Flash Bus Cycle Decoder

This block sits on the device side of an 8-bit asynchronous NAND flash bus and turns pin activity into clean single-cycle events in the system clock domain. Every control pin and the I/O byte first pass through a two-flop synchronizer. The chip enable, write strobe and read strobe then pass through a short glitch filter, so a level must persist for `FILT_LEN` consecutive samples before it is accepted. Each rising edge of the filtered write strobe is classified by the latch pins as a command, address or data-input cycle.

Commands are reported with their byte. Address bytes are gathered into a wide address that is reported once the last byte arrives. Data bytes are streamed out one at a time toward a page-buffer write port. Commands that begin a program or erase are refused while write protect is asserted, and a flag is raised instead. The most recent read-type command selects which source a later read cycle returns, and this choice is exposed as a 2-bit select.

Top module: `nand_bus_decoder`

## Requirements
- R1: A write-strobe rising edge with chip enable low, command latch high, address latch low and read strobe high produces a one-cycle `cmd_valid` with `cmd_byte` equal to the I/O byte.
- R2: Four address cycles (address latch high, command latch low, chip enable low, read strobe high) produce one `addr_valid` pulse after the fourth. The first byte sits in `addr[7:0]` and the fourth in `addr[31:24]`.
- R3: A write-strobe rising edge with both latches low, chip enable low, read strobe high and write protect high produces a `data_valid` pulse carrying that byte. With write protect low, no pulse is produced.
- R4: The command bytes 0x80, 0x60 and 0x85 start program or erase. While write protect is low, such a command gives no `cmd_valid` and instead pulses `wp_violation`.
- R5: Any recognised command cycle, accepted or refused, restarts the address byte count, so a partial address is discarded.
- R6: An address cycle arriving after a complete address and before the next command pulses `addr_overflow`, gives no `addr_valid` and leaves `addr` unchanged.
- R7: While chip enable is high, no cycle produces an event and the address byte count is held at zero.
- R8: A write-strobe low pulse shorter than `FILT_LEN` samples (default 2) is ignored. A pulse of exactly `FILT_LEN` samples is accepted.
- R9: `read_src` resets to 0. The accepted commands 0x00, 0x70, 0x90 and 0xED set it to 0 (array), 1 (status), 2 (signature) and 3 (unique ID). Other commands leave it unchanged.
- R10: After reset every event output is low. Each event is a single-cycle pulse, and at most one event fires per cycle.
- R11: A write-strobe edge with both latches high, or with read strobe low, produces no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en_n | input | 1 | Bus chip enable, active low |
| cmd_latch | input | 1 | Command latch pin |
| addr_latch | input | 1 | Address latch pin |
| wr_strobe_n | input | 1 | Write strobe, bytes taken on its rising edge |
| rd_strobe_n | input | 1 | Read strobe, active low |
| wr_protect_n | input | 1 | Write protect, low blocks modify operations |
| io_bus | input | 8 | Bus I/O byte |
| cmd_valid | output | 1 | Command event pulse |
| cmd_byte | output | 8 | Accepted command byte |
| addr_valid | output | 1 | Full-address event pulse |
| addr | output | 32 | Gathered address, first byte in the low bits |
| data_valid | output | 1 | Data-input event pulse |
| data_byte | output | 8 | Data-input byte |
| read_src | output | 2 | Selected read source |
| wp_violation | output | 1 | Pulse when a modify command is refused |
| addr_overflow | output | 1 | Pulse on a surplus address byte |

## Verification
The bench targets a one-sample strobe pulse that a missing or too-short filter would turn into a spurious command. It checks a fifth address byte, which a counter without saturation would wrap into a fresh address and report. It also checks a command that interrupts a partial address; a counter that is not restarted would assemble a wrong address from stale bytes. Finally, it applies erase setup under write protect, which a missing gate would pass as a normal command, and data input under write protect, which would leak data into the page buffer.

// File: rtl/nand_bus_decoder.sv
module nand_bus_decoder #(
  parameter int FILT_LEN   = 2,
  parameter int ADDR_BYTES = 4,
  localparam int AW = 8 * ADDR_BYTES,
  localparam int CW = $clog2(ADDR_BYTES + 1),
  localparam int FW = $clog2(FILT_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chip_en_n,
  input  logic          cmd_latch,
  input  logic          addr_latch,
  input  logic          wr_strobe_n,
  input  logic          rd_strobe_n,
  input  logic          wr_protect_n,
  input  logic [7:0]    io_bus,
  output logic          cmd_valid,
  output logic [7:0]    cmd_byte,
  output logic          addr_valid,
  output logic [AW-1:0] addr,
  output logic          data_valid,
  output logic [7:0]    data_byte,
  output logic [1:0]    read_src,
  output logic          wp_violation,
  output logic          addr_overflow
);

  // strobe group index: 2 = chip enable, 1 = write, 0 = read
  logic [2:0] st_m, st_s, st_f;
  logic [2:0] lt_m, lt_s;
  logic [7:0] io_m, io_s;
  logic [FW-1:0] fcnt [3];
  logic we_prev;
  logic [CW-1:0] addr_cnt;
  logic [AW-1:0] addr_buf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st_m <= 3'b111; st_s <= 3'b111;
      lt_m <= 3'b000; lt_s <= 3'b000;
      io_m <= '0;     io_s <= '0;
    end else begin
      st_m <= {chip_en_n, wr_strobe_n, rd_strobe_n}; st_s <= st_m;
      lt_m <= {cmd_latch, addr_latch, wr_protect_n}; lt_s <= lt_m;
      io_m <= io_bus; io_s <= io_m;
    end

  for (genvar g = 0; g < 3; g++) begin : g_filt
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        st_f[g] <= 1'b1;
        fcnt[g] <= '0;
      end else if (st_s[g] == st_f[g]) begin
        fcnt[g] <= '0;
      end else if (fcnt[g] == FW'(FILT_LEN - 1)) begin
        st_f[g] <= st_s[g];
        fcnt[g] <= '0;
      end else begin
        fcnt[g] <= fcnt[g] + 1'b1;
      end
  end

  wire ce_f   = st_f[2];
  wire we_f   = st_f[1];
  wire re_f   = st_f[0];
  wire we_s   = st_s[1];
  wire cle_s  = lt_s[2];
  wire ale_s  = lt_s[1];
  wire wp_s   = lt_s[0];

  wire we_rise  = we_f & ~we_prev;
  wire bus_ok   = we_rise & ~ce_f & re_f;
  wire cyc_cmd  = bus_ok & cle_s & ~ale_s;
  wire cyc_addr = bus_ok & ale_s & ~cle_s;
  wire cyc_data = bus_ok & ~ale_s & ~cle_s & wp_s;
  wire is_mod   = (io_s == 8'h80) || (io_s == 8'h60) || (io_s == 8'h85);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      we_prev <= 1'b1;
      cmd_valid <= 1'b0; addr_valid <= 1'b0; data_valid <= 1'b0;
      wp_violation <= 1'b0; addr_overflow <= 1'b0;
      cmd_byte <= '0; data_byte <= '0; addr <= '0; addr_buf <= '0;
      addr_cnt <= '0; read_src <= 2'd0;
    end else begin
      we_prev <= we_f;
      cmd_valid <= 1'b0; addr_valid <= 1'b0; data_valid <= 1'b0;
      wp_violation <= 1'b0; addr_overflow <= 1'b0;
      if (ce_f) begin
        addr_cnt <= '0;
      end else if (cyc_cmd) begin
        addr_cnt <= '0;
        if (is_mod && !wp_s) begin
          wp_violation <= 1'b1;
        end else begin
          cmd_valid <= 1'b1;
          cmd_byte  <= io_s;
          case (io_s)
            8'h00:   read_src <= 2'd0;
            8'h70:   read_src <= 2'd1;
            8'h90:   read_src <= 2'd2;
            8'hED:   read_src <= 2'd3;
            default: ;
          endcase
        end
      end else if (cyc_addr) begin
        if (addr_cnt == CW'(ADDR_BYTES)) begin
          addr_overflow <= 1'b1;
        end else begin
          addr_buf[8*int'(addr_cnt) +: 8] <= io_s;
          addr_cnt <= addr_cnt + 1'b1;
          if (addr_cnt == CW'(ADDR_BYTES - 1)) begin
            addr_valid <= 1'b1;
            addr <= {io_s, addr_buf[AW-9:0]};
          end
        end
      end else if (cyc_data) begin
        data_valid <= 1'b1;
        data_byte  <= io_s;
      end
    end

endmodule

module nand_bus_decoder_chk #(
  parameter int ADDR_BYTES = 4,
  localparam int CW = $clog2(ADDR_BYTES + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [7:0]    cmd_byte,
  input logic          addr_valid,
  input logic          data_valid,
  input logic          wp_violation,
  input logic          addr_overflow,
  input logic          ce_f,
  input logic          we_f,
  input logic          we_s,
  input logic          wp_s,
  input logic [CW-1:0] addr_cnt
);
  wire mod_cmd = (cmd_byte == 8'h80) || (cmd_byte == 8'h60) || (cmd_byte == 8'h85);

  assert_single_event_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, addr_valid, data_valid, wp_violation, addr_overflow}));
  assert_cmd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  assert_mod_gated_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && mod_cmd) |-> $past(wp_s));
  assert_data_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> $past(wp_s));
  assert_ce_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ce_f |=> (addr_cnt == '0 && !cmd_valid && !addr_valid && !data_valid));
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    addr_cnt <= CW'(ADDR_BYTES));
  assert_cmd_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid || wp_violation) |-> addr_cnt == '0);
  assert_filter_settled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_f != $past(we_f)) |-> ($past(we_s) == we_f));
endmodule

bind nand_bus_decoder nand_bus_decoder_chk #(.ADDR_BYTES(ADDR_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .addr_valid(addr_valid), .data_valid(data_valid), .wp_violation(wp_violation),
  .addr_overflow(addr_overflow), .ce_f(ce_f), .we_f(we_f), .we_s(we_s),
  .wp_s(wp_s), .addr_cnt(addr_cnt)
);

// File: tb/tb_nand_bus_decoder.sv
module tb_nand_bus_decoder;
  logic clk = 1'b0, rst_n = 1'b0;
  logic chip_en_n = 1'b1, cmd_latch = 1'b0, addr_latch = 1'b0;
  logic wr_strobe_n = 1'b1, rd_strobe_n = 1'b1, wr_protect_n = 1'b1;
  logic [7:0] io_bus = '0;
  logic cmd_valid, addr_valid, data_valid, wp_violation, addr_overflow;
  logic [7:0] cmd_byte, data_byte;
  logic [31:0] addr;
  logic [1:0] read_src;

  nand_bus_decoder dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  int mon_cmd = 0, mon_addr = 0, mon_data = 0, mon_viol = 0, mon_ovf = 0;
  logic [7:0] mon_cmd_b, mon_data_b;
  logic [31:0] mon_addr_v;

  int m_cnt = 0;
  logic [31:0] m_addr = '0, m_last_addr = '0;
  logic [1:0] m_src = 2'd0;

  always @(negedge clk) if (rst_n) begin
    if (cmd_valid)     begin mon_cmd++;  mon_cmd_b  = cmd_byte;  end
    if (addr_valid)    begin mon_addr++; mon_addr_v = addr;      end
    if (data_valid)    begin mon_data++; mon_data_b = data_byte; end
    if (wp_violation)  mon_viol++;
    if (addr_overflow) mon_ovf++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit is_mod(input logic [7:0] b);
    return b == 8'h80 || b == 8'h60 || b == 8'h85;
  endfunction

  function automatic logic [1:0] src_of(input logic [7:0] b, input logic [1:0] cur);
    case (b)
      8'h00: return 2'd0;
      8'h70: return 2'd1;
      8'h90: return 2'd2;
      8'hED: return 2'd3;
      default: return cur;
    endcase
  endfunction

  // kind: 0 command, 1 address, 2 data, 3 both latches high
  task automatic bus_op(input int kind, input logic [7:0] b, input bit wp, input bit ce,
                        input bit re, input int low_len);
    @(negedge clk);
    chip_en_n = ce; cmd_latch = (kind == 0 || kind == 3); addr_latch = (kind == 1 || kind == 3);
    rd_strobe_n = re; wr_protect_n = wp; io_bus = b;
    repeat (5) @(negedge clk);
    wr_strobe_n = 1'b0;
    repeat (low_len) @(negedge clk);
    wr_strobe_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_op(input int kind, input logic [7:0] b, input bit wp, input bit ce,
                       input bit re, input int low_len, input string req);
    int c0 = mon_cmd, a0 = mon_addr, d0 = mon_data, v0 = mon_viol, o0 = mon_ovf;
    bit e_cmd = 0, e_addr = 0, e_data = 0, e_viol = 0, e_ovf = 0;
    bus_op(kind, b, wp, ce, re, low_len);
    if (ce) m_cnt = 0;
    else if (re && low_len >= 2) begin
      if (kind == 0) begin
        m_cnt = 0;
        if (is_mod(b) && !wp) e_viol = 1;
        else begin e_cmd = 1; m_src = src_of(b, m_src); end
      end else if (kind == 1) begin
        if (m_cnt == 4) e_ovf = 1;
        else begin
          m_addr[8*m_cnt +: 8] = b;
          m_cnt++;
          if (m_cnt == 4) begin e_addr = 1; m_last_addr = m_addr; end
        end
      end else if (kind == 2) e_data = wp;
    end
    chk(mon_cmd - c0 == int'(e_cmd), {req, " cmd count"}, mon_cmd - c0, e_cmd);
    if (e_cmd) chk(mon_cmd_b == b, {req, " cmd byte"}, mon_cmd_b, b);
    chk(mon_addr - a0 == int'(e_addr), {req, " addr count"}, mon_addr - a0, e_addr);
    if (e_addr) chk(mon_addr_v == m_last_addr, {req, " addr value"}, mon_addr_v, m_last_addr);
    chk(mon_data - d0 == int'(e_data), {req, " data count"}, mon_data - d0, e_data);
    if (e_data) chk(mon_data_b == b, {req, " data byte"}, mon_data_b, b);
    chk(mon_viol - v0 == int'(e_viol), {req, " protect flag"}, mon_viol - v0, e_viol);
    chk(mon_ovf - o0 == int'(e_ovf), {req, " overflow flag"}, mon_ovf - o0, e_ovf);
    chk(read_src == m_src, "R9 read_src", read_src, m_src);
    if (e_ovf || ce) chk(addr == m_last_addr, "R6 addr held", addr, m_last_addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk({cmd_valid, addr_valid, data_valid, wp_violation, addr_overflow} == 5'b0,
        "R10 reset events", {cmd_valid, addr_valid, data_valid, wp_violation, addr_overflow}, 0);
    chk(read_src == 2'd0, "R9 reset read_src", read_src, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    do_op(0, 8'h00, 1, 0, 1, 4, "R1 read command");
    do_op(0, 8'h70, 1, 0, 1, 4, "R9 status command");
    do_op(0, 8'h90, 1, 0, 1, 4, "R9 signature command");
    do_op(0, 8'hED, 1, 0, 1, 4, "R9 unique id command");
    do_op(0, 8'h30, 1, 0, 1, 4, "R9 other command keeps");
    do_op(1, 8'h11, 1, 0, 1, 4, "R2 addr byte 1");
    do_op(1, 8'h22, 1, 0, 1, 4, "R2 addr byte 2");
    do_op(1, 8'h33, 1, 0, 1, 4, "R2 addr byte 3");
    do_op(1, 8'h44, 1, 0, 1, 4, "R2 addr byte 4");
    do_op(1, 8'h55, 1, 0, 1, 4, "R6 fifth addr byte");
    do_op(0, 8'h80, 1, 0, 1, 4, "R4 program with wp high");
    do_op(1, 8'hA1, 1, 0, 1, 4, "R5 partial addr");
    do_op(1, 8'hA2, 1, 0, 1, 4, "R5 partial addr");
    do_op(0, 8'h60, 0, 0, 1, 4, "R4 erase refused");
    do_op(0, 8'h85, 0, 0, 1, 4, "R4 random input refused");
    for (int i = 0; i < 4; i++) do_op(1, 8'hB0 + 8'(i), 1, 0, 1, 4, "R5 fresh addr");
    do_op(2, 8'h5A, 1, 0, 1, 4, "R3 data wp high");
    do_op(2, 8'hC3, 0, 0, 1, 4, "R3 data wp low");
    do_op(1, 8'hD1, 1, 0, 1, 4, "R7 addr before ce high");
    do_op(0, 8'h00, 1, 1, 1, 4, "R7 command ce high");
    do_op(2, 8'h77, 1, 1, 1, 4, "R7 data ce high");
    for (int i = 0; i < 4; i++) do_op(1, 8'hE0 + 8'(i), 1, 0, 1, 4, "R7 addr after ce");
    do_op(0, 8'h70, 1, 0, 1, 1, "R8 one sample glitch");
    do_op(0, 8'h70, 1, 0, 1, 2, "R8 two sample pulse");
    do_op(3, 8'h00, 1, 0, 1, 4, "R11 both latches");
    do_op(0, 8'h90, 1, 0, 0, 4, "R11 read strobe low");

    for (int i = 0; i < 300; i++) begin
      int k = $urandom % 4;
      logic [7:0] b = 8'($urandom);
      int pick = $urandom % 8;
      if (k == 0 && pick < 6) b = (pick == 0) ? 8'h00 : (pick == 1) ? 8'h70 :
                                  (pick == 2) ? 8'h90 : (pick == 3) ? 8'hED :
                                  (pick == 4) ? 8'h80 : 8'h60;
      do_op(k, b, ($urandom % 4) != 0, ($urandom % 10) == 0, ($urandom % 8) != 0,
            1 + ($urandom % 4), "R1 R2 R3 random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule